// File: doc/BRIEF.md
# Strobed Handshake Input Port

This block is one byte-wide input channel of a parallel peripheral interface. A peripheral places a byte on its data pins and pulls an active-low strobe; while the strobe is low the byte is captured into a holding latch. The block then raises a buffer-full flag back to the peripheral so that it waits before sending more. Once the strobe has been released, and if software has enabled it, the block asks the CPU for service on an interrupt line.

The CPU collects the byte through an active-low read strobe. The interrupt drops as soon as the read begins. The buffer-full flag stays set until the read ends, which lets the peripheral send the next byte. The interrupt enable is one bit of a single-bit set/reset command word. A parameter selects which bit position of that command the channel answers to: 4 for the first channel of a pair, 2 for the second. All pin inputs pass through a synchronizer, so every response appears a fixed number of clock edges after the pin changes.

Top module: `hsin_port`

## Requirements
- R1: After a synchronous reset, the buffer-full flag is 0, the interrupt is 0, the interrupt enable is cleared and the data output is 0.
- R2: While the strobe is low, the latch follows the peripheral data. The data output holds the last byte sampled before the strobe rose. Data that changes while the strobe is high does not reach the data output.
- R3: The falling edge of the strobe sets the buffer-full flag.
- R4: The interrupt is the registered AND of four terms: buffer full, enable set, strobe high and read high. It stays low for as long as the strobe is low.
- R5: The interrupt falls when the read strobe goes low. The buffer-full flag stays set while the read is low.
- R6: The rising edge of the read strobe clears the buffer-full flag, and the interrupt stays low after it.
- R7: A strobe that arrives while the buffer is full overwrites the latch. The flag stays set.
- R8: A command byte with bit 7 = 0 and bits 3:1 equal to INTE_BIT (default 4) writes bit 0 into the interrupt enable, 1 = enabled. This takes effect even while the buffer is already full.
- R9: Command bytes with bit 7 = 1, or with bits 3:1 different from INTE_BIT, leave the interrupt enable unchanged.
- R10: With SYNC_STAGES = 2, the buffer-full flag changes on the third rising clock edge after a strobe pin change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| per_data_i | input | DW | Peripheral data pins |
| per_stb_n_i | input | 1 | Peripheral strobe, active low |
| per_full_o | output | 1 | Buffer-full flag to the peripheral |
| cpu_rd_n_i | input | 1 | CPU read strobe, active low |
| cpu_data_o | output | DW | Latched byte to the CPU |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| cmd_we_i | input | 1 | Command byte write enable, one clock |
| cmd_i | input | 8 | Command byte (bit set/reset format) |

## Verification
The hardest state to reach is an enable change that lands while a byte is already waiting. This covers clearing the enable so that the interrupt is held off with the flag still set, then setting it again so that the interrupt appears without any new strobe. The bench fills the buffer and releases the strobe first, then issues the commands, including the decoy commands with bit 7 set or a different bit selected. A second hard case is a strobe arriving on a full buffer. The bench reaches it by strobing twice without a read in between.

// File: rtl/hsin_pkg.sv
package hsin_pkg;
  localparam int CMD_W = 8;
  // command byte layout: [7] mode word flag, [3:1] bit select, [0] value
  localparam logic [CMD_W-1:0] CMD_MASK = 8'h8E;

  function automatic logic cmd_hits(input logic [CMD_W-1:0] cmd,
                                    input logic [2:0] sel);
    return (cmd & CMD_MASK) == {1'b0, 3'b000, sel, 1'b0};
  endfunction
endpackage

// File: rtl/hsin_sync.sv
module hsin_sync #(
  parameter int W = 10,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsin_inte.sv
module hsin_inte
  import hsin_pkg::*;
#(
  parameter int SEL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CMD_W-1:0] cmd,
  output logic             inte
);
  localparam logic [2:0] SEL_CODE = 3'(SEL);

  always_ff @(posedge clk) begin
    if (rst)                                inte <= 1'b0;
    else if (we && cmd_hits(cmd, SEL_CODE)) inte <= cmd[0];
  end
endmodule

// File: rtl/hsin_ctl.sv
module hsin_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] data_s,
  input  logic          stb_s,
  input  logic          rd_s,
  input  logic          inte,
  output logic          stb_prev,
  output logic          rd_prev,
  output logic [DW-1:0] latch_q,
  output logic          full_q,
  output logic          irq_q
);
  logic stb_fall, rd_rise, full_d, irq_d;

  assign stb_fall = stb_prev & ~stb_s;
  assign rd_rise  = ~rd_prev & rd_s;

  always_comb begin
    if (stb_fall)     full_d = 1'b1;
    else if (rd_rise) full_d = 1'b0;
    else              full_d = full_q;
    irq_d = full_d & inte & stb_s & rd_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev <= 1'b1;
      rd_prev  <= 1'b1;
      latch_q  <= '0;
      full_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      stb_prev <= stb_s;
      rd_prev  <= rd_s;
      if (!stb_s) latch_q <= data_s;
      full_q   <= full_d;
      irq_q    <= irq_d;
    end
  end
endmodule

// File: rtl/hsin_port.sv
module hsin_port
  import hsin_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INTE_BIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    per_data_i,
  input  logic             per_stb_n_i,
  output logic             per_full_o,
  input  logic             cpu_rd_n_i,
  output logic [DW-1:0]    cpu_data_o,
  output logic             cpu_irq_o,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i
);
  localparam int SW = DW + 2;
  localparam logic [SW-1:0] SYNC_RST = {2'b11, {DW{1'b0}}};

  logic [SW-1:0] pins_s;
  logic [DW-1:0] data_s;
  logic stb_s, rd_s, stb_q, rd_q, inte_q;

  hsin_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({per_stb_n_i, cpu_rd_n_i, per_data_i}),
    .q(pins_s)
  );

  assign stb_s  = pins_s[SW-1];
  assign rd_s   = pins_s[SW-2];
  assign data_s = pins_s[DW-1:0];

  hsin_inte #(.SEL(INTE_BIT)) u_inte (
    .clk(clk), .rst(rst), .we(cmd_we_i), .cmd(cmd_i), .inte(inte_q)
  );

  hsin_ctl #(.DW(DW)) u_ctl (
    .clk(clk), .rst(rst),
    .data_s(data_s), .stb_s(stb_s), .rd_s(rd_s), .inte(inte_q),
    .stb_prev(stb_q), .rd_prev(rd_q),
    .latch_q(cpu_data_o), .full_q(per_full_o), .irq_q(cpu_irq_o)
  );
endmodule

// File: rtl/hsin_port_chk.sv
module hsin_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          stb_s,
  input logic          stb_q,
  input logic          rd_s,
  input logic          rd_q,
  input logic          inte_q,
  input logic          per_full_o,
  input logic          cpu_irq_o,
  input logic [DW-1:0] cpu_data_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!per_full_o && !cpu_irq_o));

  p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
    stb_s |=> $stable(cpu_data_o));

  p_fall_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (stb_q && !stb_s) |=> per_full_o);

  p_irq_needs_full_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o |-> per_full_o);

  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o |-> $past(inte_q));

  p_no_irq_in_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !stb_s |=> !cpu_irq_o);

  p_read_drops_irq_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_s |=> !cpu_irq_o);

  p_full_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (per_full_o && !(rd_s && !rd_q)) |=> per_full_o);
endmodule

bind hsin_port hsin_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .stb_s(stb_s), .stb_q(stb_q), .rd_s(rd_s),
  .rd_q(rd_q), .inte_q(inte_q), .per_full_o(per_full_o),
  .cpu_irq_o(cpu_irq_o), .cpu_data_o(cpu_data_o)
);

// File: tb/hsin_port_tb.sv
module hsin_port_tb;
  localparam int DW = 8;
  localparam logic [7:0] EN_SET = 8'h09;
  localparam logic [7:0] EN_CLR = 8'h08;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] per_data_i = '0;
  logic per_stb_n_i = 1'b1;
  logic cpu_rd_n_i = 1'b1;
  logic cmd_we_i = 1'b0;
  logic [7:0] cmd_i = '0;
  logic per_full_o, cpu_irq_o;
  logic [DW-1:0] cpu_data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hsin_port #(.DW(DW), .SYNC_STAGES(2), .INTE_BIT(4)) u_dut (
    .clk(clk), .rst(rst), .per_data_i(per_data_i), .per_stb_n_i(per_stb_n_i),
    .per_full_o(per_full_o), .cpu_rd_n_i(cpu_rd_n_i), .cpu_data_o(cpu_data_o),
    .cpu_irq_o(cpu_irq_o), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    cmd_i = c; cmd_we_i = 1'b1;
    wait_cyc(1);
    cmd_we_i = 1'b0;
    wait_cyc(3);
  endtask

  task automatic strobe(input logic [DW-1:0] d);
    per_data_i = d; per_stb_n_i = 1'b0;
    wait_cyc(4);
    per_stb_n_i = 1'b1;
    wait_cyc(4);
  endtask

  task automatic do_read;
    cpu_rd_n_i = 1'b0;
    wait_cyc(4);
    cpu_rd_n_i = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    check("R1", "full after reset", per_full_o, 0);
    check("R1", "irq after reset", cpu_irq_o, 0);
    check("R1", "data after reset", cpu_data_o, 0);
  endtask

  task automatic t_latency;
    per_data_i = 8'h77; per_stb_n_i = 1'b0;
    wait_cyc(2);
    check("R10", "full after two edges", per_full_o, 0);
    wait_cyc(1);
    check("R10", "full after three edges", per_full_o, 1);
    wait_cyc(2);
    per_stb_n_i = 1'b1;
    wait_cyc(4);
    check("R1", "irq with enable still cleared from reset", cpu_irq_o, 0);
    do_read();
    check("R6", "full cleared by read end", per_full_o, 0);
  endtask

  task automatic t_capture;
    per_data_i = 8'hA5; per_stb_n_i = 1'b0;
    wait_cyc(4);
    check("R3", "full on strobe fall", per_full_o, 1);
    check("R2", "latch follows while low", cpu_data_o, 8'hA5);
    per_data_i = 8'h3C;
    wait_cyc(4);
    check("R2", "latch tracks change while low", cpu_data_o, 8'h3C);
    per_stb_n_i = 1'b1;
    wait_cyc(4);
    per_data_i = 8'hFF;
    wait_cyc(4);
    check("R2", "data held after strobe rise", cpu_data_o, 8'h3C);
    do_read();
    check("R6", "full cleared", per_full_o, 0);
  endtask

  task automatic t_irq_flow;
    send_cmd(EN_SET);
    per_data_i = 8'h5A; per_stb_n_i = 1'b0;
    wait_cyc(5);
    check("R4", "no irq while strobe low", cpu_irq_o, 0);
    per_stb_n_i = 1'b1;
    wait_cyc(4);
    check("R4", "irq after strobe high", cpu_irq_o, 1);
    cpu_rd_n_i = 1'b0;
    wait_cyc(4);
    check("R5", "irq dropped by read start", cpu_irq_o, 0);
    check("R5", "full held during read", per_full_o, 1);
    check("R5", "data during read", cpu_data_o, 8'h5A);
    cpu_rd_n_i = 1'b1;
    wait_cyc(4);
    check("R6", "full cleared by read end", per_full_o, 0);
    check("R6", "irq stays low after read", cpu_irq_o, 0);
  endtask

  task automatic t_overwrite;
    strobe(8'h11);
    check("R7", "first byte", cpu_data_o, 8'h11);
    strobe(8'h22);
    check("R7", "second byte overwrote", cpu_data_o, 8'h22);
    check("R7", "full stays set", per_full_o, 1);
    check("R7", "irq still raised", cpu_irq_o, 1);
    do_read();
    check("R7", "full cleared after read", per_full_o, 0);
  endtask

  task automatic t_enable_cmds;
    strobe(8'h66);
    check("R4", "irq with enable set", cpu_irq_o, 1);
    send_cmd(8'h88);
    check("R9", "mode-flag command ignored", cpu_irq_o, 1);
    send_cmd(8'h06);
    check("R9", "other-bit command ignored", cpu_irq_o, 1);
    send_cmd(EN_CLR);
    check("R8", "clear drops irq", cpu_irq_o, 0);
    check("R8", "full unaffected by clear", per_full_o, 1);
    send_cmd(EN_SET);
    check("R8", "set while full raises irq", cpu_irq_o, 1);
    do_read();
    send_cmd(EN_CLR);
    strobe(8'h99);
    check("R8", "no irq when disabled", cpu_irq_o, 0);
    check("R8", "full when disabled", per_full_o, 1);
    do_read();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_capture();
    t_irq_flow();
    t_overwrite();
    t_enable_cmds();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule